// File: doc/BRIEF.md
# Byte-Bus Timekeeping Register Front End

This block sits between a byte-wide chip-select/write-enable/output-enable bus and two back ends: a plain byte RAM, and a set of external time-of-day counters. The eight highest byte addresses hold the clock registers. Every lower address goes to the RAM. The clock registers are a holding copy of the time, kept apart from the live counters. While neither halt bit is set, the holding copy follows the counters on every cycle. A read-halt bit freezes the copy so software can read a consistent snapshot while the counters keep running. A write-halt bit lets software fill in new time fields. Clearing it sends them to the counters as a one-cycle load.

An oscillator-stop bit is driven out to the counters as a run enable. A frequency-test bit makes the seconds LSB, as read back, flip on each 512 Hz strobe. A power-fail input blocks every access and drives an active-low power-fail output. Bits that carry no clock function act as ordinary storage.

Top module: `rtc_reg_front`

## Requirements
- R1: With `ADDR_W` address bits, the top eight addresses map to the clock registers. Address low bits 0 to 7 select, in order: control, seconds, minutes, hour, day, date, month, year. Every lower address reads and writes a RAM byte.
- R2: While control bit 6 (read halt) is 1, the time fields of the clock registers read back unchanged, whatever the live counters do.
- R3: While control bit 7 (write halt) is 1, the time fields follow bus writes and not the counters. A write that takes bit 7 from 1 to 0 pulses `ld_stb` for exactly one cycle, one cycle after the write. During that pulse `ld_time` carries the time fields, seconds in bits 7:0 up to year in bits 55:48.
- R4: While both halt bits are 0, the time fields of the clock registers track `cnt_time`. A read issued two cycles after the counters or a halt bit change returns the new values.
- R5: Seconds bit 7 is the oscillator stop bit. When it is 1, `osc_run` is 0 from the next cycle on.
- R6: Day bit 6 is the frequency-test bit. While it is 1 and `osc_run` is 1, each `tick_512` pulse inverts bit 0 of the seconds value as read back. Otherwise no inversion is applied.
- R7: The time-field masks are: seconds 0x7F, minutes 0x7F, hour 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF, control 0x00. All bits outside the masks store written data like RAM. Time-field bits written while bit 7 is 0 are discarded.
- R8: While `pf_in` is 1, `pfo_n` is 0. All reads and writes to RAM and clock registers are ignored, with no output enable and no load pulse.
- R9: A read takes `ce_n`=0, `we_n`=1 and `oe_n`=0 at a clock edge. It drives `dq_oe`=1 and the data on `dq_out` after that edge. In all other cases `dq_oe` is 0. A write takes `ce_n`=0 and `we_n`=0.
- R10: After reset, `dq_oe`=0, `ld_stb`=0, `osc_run`=1 and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data valid / bus drive enable |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pf_in | input | 1 | Power-fail indication, active high |
| pfo_n | output | 1 | Power-fail output, active low |
| tick_512 | input | 1 | 512 Hz single-cycle strobe |
| cnt_time | input | 56 | Live counter time fields, seconds in the low byte |
| ld_time | output | 56 | Time fields to load into the counters |
| ld_stb | output | 1 | One-cycle counter load strobe |
| osc_run | output | 1 | Timekeeping run enable |

## Verification
The bench changes the live counters while read halt is set and expects the old seconds. A design that let the copy track would show the new value. It sets write halt, writes fields, then clears it. The load pulse must be one cycle wide and must carry the written values. A design that refreshed the copy during the pulse would lose the new time. It writes all-ones to a time register with write halt clear. Only the storage bit may survive. It also toggles the frequency-test read-back across an oscillator stop, where a leftover toggle state would corrupt the seconds LSB. Finally it issues writes under power fail that must leave RAM and control unchanged.

// File: rtl/rtc_reg_front.sv
module rtc_reg_front #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pf_in,
  output logic              pfo_n,
  input  logic              tick_512,
  input  logic [55:0]       cnt_time,
  output logic [55:0]       ld_time,
  output logic              ld_stb,
  output logic              osc_run
);
  localparam int RAM_DEPTH = (1 << ADDR_W) - 8;

  function automatic logic [7:0] tmask(input logic [2:0] i);
    case (i)
      3'd0:    tmask = 8'h00;
      3'd1:    tmask = 8'h7F;
      3'd2:    tmask = 8'h7F;
      3'd3:    tmask = 8'h3F;
      3'd4:    tmask = 8'h07;
      3'd5:    tmask = 8'h3F;
      3'd6:    tmask = 8'h1F;
      default: tmask = 8'hFF;
    endcase
  endfunction

  logic [7:0] hold    [8];
  logic [7:0] hold_nx [8];
  logic [7:0] mem [RAM_DEPTH];
  logic [7:0] mem_q, clk_q;
  logic       src_clk_q, oe_q, ld_q, tog;

  wire        sel    = ~ce_n & ~pf_in;
  wire        is_clk = &addr[ADDR_W-1:3];
  wire [2:0]  idx    = addr[2:0];
  wire        wr     = sel & ~we_n;
  wire        rd     = sel & we_n & ~oe_n;
  wire        clk_wr = wr & is_clk;
  wire        wbit   = hold[0][7];
  wire        rbit   = hold[0][6];
  wire        ft     = hold[4][6];
  wire        refresh = ~wbit & ~rbit & ~ld_q;

  assign pfo_n   = ~pf_in;
  assign osc_run = ~hold[1][7];
  assign ld_stb  = ld_q;
  assign dq_oe   = oe_q;
  assign dq_out  = src_clk_q ? clk_q : mem_q;

  always_comb begin
    for (int i = 1; i < 8; i++)
      ld_time[8*(i-1) +: 8] = hold[i] & tmask(3'(i));
  end

  always_comb begin
    for (int i = 0; i < 8; i++) hold_nx[i] = hold[i];
    if (refresh)
      for (int i = 1; i < 8; i++)
        hold_nx[i] = (hold[i] & ~tmask(3'(i))) | (cnt_time[8*(i-1) +: 8] & tmask(3'(i)));
    if (clk_wr)
      for (int i = 0; i < 8; i++)
        if (idx == 3'(i))
          hold_nx[i] = wbit ? dq_in
                            : (hold_nx[i] & tmask(3'(i))) | (dq_in & ~tmask(3'(i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) hold[i] <= 8'h00;
      ld_q <= 1'b0;
      tog  <= 1'b0;
      oe_q <= 1'b0;
      clk_q <= 8'h00;
      src_clk_q <= 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) hold[i] <= hold_nx[i];
      ld_q <= clk_wr && idx == 3'd0 && wbit && !dq_in[7];
      if (!(ft && osc_run)) tog <= 1'b0;
      else if (tick_512)    tog <= ~tog;
      oe_q <= rd;
      if (rd) begin
        src_clk_q <= is_clk;
        clk_q <= (idx == 3'd1) ? (hold[1] ^ {7'b0, tog}) : hold[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !is_clk) mem[addr] <= dq_in;
    if (rd && !is_clk) mem_q <= mem[addr];
  end

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rbit) && !$past(clk_wr) |-> $stable(ld_time));
  assert_ld_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb);
  assert_ft_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |=> !tog);
  assert_pf_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_in |=> !dq_oe);
  assert_pf_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_in |=> !ld_stb);
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe);
endmodule

// File: tb/tb_rtc_reg_front.sv
`timescale 1ns/1ps
module tb_rtc_reg_front;
  localparam int AW = 10;
  localparam logic [AW-1:0] CB = 10'd1016;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = 0, dq_out;
  logic dq_oe, ce_n = 1, we_n = 1, oe_n = 1, pf_in = 0, pfo_n, tick = 0;
  logic [55:0] cnt = '0, ld_time;
  logic ld_stb, osc_run;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rtc_reg_front #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pf_in(pf_in),
    .pfo_n(pfo_n), .tick_512(tick), .cnt_time(cnt), .ld_time(ld_time),
    .ld_stb(ld_stb), .osc_run(osc_run));

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (dq_oe) begin
    if (exp_q.size() == 0) chk("R8/R9 unexpected read data", 1, 0);
    else chk(tag_q.pop_front(), dq_out, exp_q.pop_front());
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; ce_n = 0; we_n = 1; oe_n = 0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    chk("R10 dq_oe", dq_oe, 0);
    chk("R10 ld_stb", ld_stb, 0);
    chk("R10 osc_run", osc_run, 1);
    chk("R8 pfo_n idle", pfo_n, 1);
    rd(CB, 8'h00, "R10 control reset");

    wr(10'd5, 8'hA5); wr(10'd1015, 8'h3C);
    rd(10'd5, 8'hA5, "R1 ram low");
    rd(10'd1015, 8'h3C, "R1 ram top");

    cnt = 56'h24_06_15_03_12_30_45;
    idle(2);
    rd(CB+1, 8'h45, "R1 R4 seconds"); rd(CB+2, 8'h30, "R1 R4 minutes");
    rd(CB+3, 8'h12, "R1 R4 hour");    rd(CB+4, 8'h03, "R1 R4 day");
    rd(CB+5, 8'h15, "R1 R4 date");    rd(CB+6, 8'h06, "R1 R4 month");
    rd(CB+7, 8'h24, "R1 R4 year");

    wr(CB+2, 8'hFF);
    rd(CB+2, 8'hB0, "R7 minutes time bits discarded");
    wr(CB, 8'h15);
    rd(CB, 8'h15, "R7 control ram bits");

    wr(CB, 8'h55);
    cnt[7:0] = 8'h46;
    idle(3);
    rd(CB+1, 8'h45, "R2 frozen seconds");
    rd(CB, 8'h55, "R2 control");
    wr(CB, 8'h15);
    idle(1);
    rd(CB+1, 8'h46, "R4 refresh after read halt");

    wr(CB, 8'h95);
    wr(CB+1, 8'h10); wr(CB+3, 8'h23);
    cnt[7:0] = 8'h50;
    idle(2);
    rd(CB+1, 8'h10, "R3 written seconds held");
    wr(CB, 8'h15);
    chk("R3 ld_stb pulse", ld_stb, 1);
    chk("R3 ld_time", ld_time, 56'h24_06_15_03_23_30_10);
    @(posedge clk); #1 cnt = ld_time;
    @(negedge clk);
    chk("R3 ld_stb single", ld_stb, 0);
    idle(2);
    rd(CB+1, 8'h10, "R3 loaded seconds");
    rd(CB+3, 8'h23, "R3 loaded hour");

    wr(CB+1, 8'h90);
    chk("R5 osc stopped", osc_run, 0);
    rd(CB+1, 8'h90, "R5 stop bit readback");
    wr(CB+1, 8'h00);
    chk("R5 osc running", osc_run, 1);

    wr(CB+4, 8'h40);
    rd(CB+4, 8'h43, "R6 R7 day ft bit");
    rd(CB+1, 8'h10, "R6 before tick");
    pulse_tick();
    rd(CB+1, 8'h11, "R6 after one tick");
    pulse_tick();
    rd(CB+1, 8'h10, "R6 after two ticks");
    pulse_tick();
    wr(CB+1, 8'h80);
    rd(CB+1, 8'h90, "R6 toggle cleared on stop");
    pulse_tick();
    rd(CB+1, 8'h90, "R6 no toggle when stopped");
    wr(CB+1, 8'h00); wr(CB+4, 8'h00);
    pulse_tick();
    rd(CB+1, 8'h10, "R6 ft off");

    @(negedge clk); pf_in = 1;
    @(negedge clk);
    chk("R8 pfo_n active", pfo_n, 0);
    wr(10'd5, 8'h00);
    wr(CB, 8'h95);
    chk("R8 no load", ld_stb, 0);
    @(negedge clk); addr = 10'd5; ce_n = 0; we_n = 1; oe_n = 0;
    @(negedge clk); ce_n = 1; oe_n = 1;
    chk("R8 read blocked", dq_oe, 0);
    pf_in = 0;
    rd(10'd5, 8'hA5, "R8 ram untouched");
    rd(CB, 8'h15, "R8 control untouched");

    @(negedge clk); addr = 10'd5; ce_n = 0; we_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 1;
    chk("R9 oe_n high no drive", dq_oe, 0);
    wr(10'd6, 8'h11);
    chk("R9 write no drive", dq_oe, 0);
    rd(10'd6, 8'h11, "R9 write then read");

    idle(2);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule